// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous on-chip requester read and write an external asynchronous static RAM of 256K words by 4 bits. On the requester side it accepts one access at a time through a valid/ready handshake that carries an address, a write flag and a write nibble. Each read returns its nibble with a one-cycle response pulse. On the memory side it drives an 18-bit address, active-low chip-select, write-strobe and read-strobe lines, and a 4-bit data path. Because the data path is split into an outgoing nibble, an incoming nibble and a drive-enable, the pad ring can build the tri-state pin from these three signals.

The controller runs from a 100 MHz clock and turns the memory's nanosecond limits into whole-cycle phases. A write holds chip-select and write-strobe low for a set number of cycles, with data driven from the first of them. It then spends one cycle with both strobes high while the address and data are still held. A read holds chip-select and read-strobe low for a set number of cycles and samples the pins at the last edge. It then spends one turnaround cycle with every strobe high, so the memory releases the bus before the controller can drive it again. After reset the controller waits a programmable number of cycles, 100 µs by default, before it will take any request. While it is idle it keeps the memory deselected.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset is released, reqReady stays low and memCeN stays high for exactly WAKE_CYCLES clock cycles, and a request presented in that time has no effect. reqReady is first high after the WAKE_CYCLES-th rising edge.
- R2: While reset is asserted, memCeN, memWeN and memOeN are 1, and memDqOe, reqReady and rspValid are 0.
- R3: A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady is 0 from the accepting edge until the access has finished.
- R4: A write (reqWrite=1) drives memCeN=0, memWeN=0, memOeN=1 and memDqOe=1, with memDqOut equal to the write nibble, for exactly WE_CYCLES cycles starting at the accepting edge. One cycle with memCeN=memWeN=1 follows, in which memDqOe=1 and the address is unchanged.
- R5: memAddr does not change while memCeN is low, and memWeN is low only while memCeN is low.
- R6: A read (reqWrite=0) drives memCeN=0, memOeN=0, memWeN=1 and memDqOe=0 for RD_CYCLES cycles and samples memDqIn at the last of those edges. rspValid is 1 for exactly one cycle, RD_CYCLES+1 cycles after the accepting edge, and rspRdata[3:0] then holds the sampled nibble.
- R7: After every read, one turnaround cycle follows with memCeN=memWeN=memOeN=1. memDqOe is never 1 while memOeN is 0, and it never rises less than 5 ns after memOeN has risen.
- R8: A read returns the nibble most recently written to the same address, including directly after a write and when a write directly follows a read.
- R9: With a 10 ns clock each write-strobe pulse lasts at least 7 ns. Write data is stable at least 6 ns before the write ends, and the address is stable at least 7 ns before it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (100 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester has an access pending |
| reqReady | output | 1 | Controller can take an access this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address of the access |
| reqWdata | input | 4 | Nibble to write |
| rspValid | output | 1 | One-cycle pulse: read data is available |
| rspRdata | output | 4 | Nibble returned by the last read |
| memAddr | output | 18 | Memory address bus |
| memCeN | output | 1 | Memory chip-select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory read strobe (output enable), active low |
| memDqOut | output | 4 | Nibble the controller drives onto the data pins |
| memDqOe | output | 1 | Enable for the controller's data-pin drivers |
| memDqIn | input | 4 | Nibble currently on the data pins |

## Verification
The bench builds the controller with WAKE_CYCLES=20 and keeps the default strobe lengths of two cycles for writes and two for reads. The short hold-off makes it possible to count the exact cycle in which reqReady first rises, and to show that a request held during the wait is dropped. The default strobe lengths make the nanosecond checks in the bench's memory model meaningful at the 10 ns clock: write pulse width, data and address setup, bus contention, and driver turn-on after the read strobe is released. A vector table of boundary addresses and alternating patterns, followed by a random write/read mix over a small address set, exercises back-to-back write-then-read and read-then-write orders.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_IDLE,
    ST_WR,
    ST_WREND,
    ST_RD,
    ST_TURN
  } ctl_state_t;

  // Strobes in active-high form; the datapath registers and inverts them.
  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
    logic drive;
  } strobe_t;

  typedef struct packed {
    strobe_t nextStb;
    logic    load;
    logic    capture;
  } ctl_t;

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WAKE_CYCLES = 10000,
  parameter int WE_CYCLES   = 2,
  parameter int RD_CYCLES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output logic rspValid,
  output ctl_t ctl
);

  localparam int MAX_STEP = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);
  localparam int WAKE_W   = $clog2(WAKE_CYCLES + 1);
  localparam logic [STEP_W-1:0] WR_LAST   = STEP_W'(WE_CYCLES - 1);
  localparam logic [STEP_W-1:0] RD_LAST   = STEP_W'(RD_CYCLES - 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_CYCLES - 1);

  ctl_state_t        state, stateNx;
  logic [STEP_W-1:0] stepCnt, stepNx;
  logic [WAKE_W-1:0] wakeCnt;
  logic              wakeDone;

  assign wakeDone = (wakeCnt == WAKE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (state == ST_WAKE && !wakeDone) begin
      wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_comb begin
    stateNx = state;
    stepNx  = stepCnt;
    unique case (state)
      ST_WAKE:  if (wakeDone) stateNx = ST_IDLE;
      ST_IDLE: begin
        stepNx = '0;
        if (reqValid) stateNx = reqWrite ? ST_WR : ST_RD;
      end
      ST_WR: begin
        if (stepCnt == WR_LAST) stateNx = ST_WREND;
        else stepNx = stepCnt + 1'b1;
      end
      ST_WREND: stateNx = ST_IDLE;
      ST_RD: begin
        if (stepCnt == RD_LAST) stateNx = ST_TURN;
        else stepNx = stepCnt + 1'b1;
      end
      ST_TURN:  stateNx = ST_IDLE;
      default:  stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAKE;
      stepCnt <= '0;
    end else begin
      state   <= stateNx;
      stepCnt <= stepNx;
    end
  end

  // Strobes for the coming cycle are decoded from the next state so the
  // datapath can present them straight from flops.
  always_comb begin
    ctl.nextStb = '0;
    unique case (stateNx)
      ST_WR: begin
        ctl.nextStb.sel   = 1'b1;
        ctl.nextStb.wr    = 1'b1;
        ctl.nextStb.drive = 1'b1;
      end
      ST_WREND: ctl.nextStb.drive = 1'b1;
      ST_RD: begin
        ctl.nextStb.sel = 1'b1;
        ctl.nextStb.rd  = 1'b1;
      end
      default: ctl.nextStb = '0;
    endcase
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.capture = (state == ST_RD) && (stepCnt == RD_LAST);
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_TURN);

  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE) |=> (state == ST_WAKE || state == ST_IDLE)); // R1

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R6

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(state) == ST_RD); // R6

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load) |=> !reqReady); // R3

endmodule

// File: rtl/sram_ctrl_dp.sv
`timescale 1ns/1ps
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t           stbQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= ctl.nextStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (ctl.capture) rdataQ <= memDqIn;
  end

  assign memAddr  = addrQ;
  assign memCeN   = ~stbQ.sel;
  assign memWeN   = ~stbQ.wr;
  assign memOeN   = ~stbQ.rd;
  assign memDqOut = wdataQ;
  assign memDqOe  = stbQ.drive;
  assign rspRdata = rdataQ;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN); // R7

  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> $past(memOeN)); // R7

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr)); // R5

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R5

  AST_DATA_HELD_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && $stable(memDqOut))); // R4

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl #(
  parameter int WAKE_CYCLES = 10000,
  parameter int WE_CYCLES   = 2,
  parameter int RD_CYCLES   = 2,
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  sram_ctrl_pkg::ctl_t ctl;

  sram_ctrl_fsm #(
    .WAKE_CYCLES(WAKE_CYCLES),
    .WE_CYCLES  (WE_CYCLES),
    .RD_CYCLES  (RD_CYCLES)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .ctl     (ctl)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rspRdata(rspRdata),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

endmodule

// File: tb/sim_async_sram_ctrl.sv
`timescale 1ns/1ps
module sim_async_sram_ctrl;

  localparam int WAKE = 20;
  localparam int WE_C = 2;
  localparam int RD_C = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        reqReady, rspValid, memCeN, memWeN, memOeN, memDqOe;
  logic [3:0]  rspRdata, memDqOut, memDqIn;
  logic [17:0] memAddr;

  always #5 clk = ~clk;

  async_sram_ctrl #(.WAKE_CYCLES(WAKE), .WE_CYCLES(WE_C), .RD_CYCLES(RD_C)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [3:0] memArr [int];
  logic [3:0] modelRd;
  logic       modelOn;
  bit         wrActive = 0;
  time        tWrStart = 0, tDataChg = 0, tAddrChg = 0, tOeRise = 0;

  assign modelOn = !memCeN && !memOeN && memWeN;
  assign memDqIn = modelOn ? modelRd : 4'h0;

  always @(memAddr or memCeN or memOeN or memWeN)
    modelRd = memArr.exists(int'(memAddr)) ? memArr[int'(memAddr)] : 4'h0;

  always @(memDqOut or memDqOe) tDataChg = $time;

  always @(memAddr) begin
    if (wrActive) check(0, "R5", "address moved during write", memAddr, 0);
    tAddrChg = $time;
  end

  always @(memDqOe or modelOn)
    if (memDqOe && modelOn) check(0, "R7", "bus contention", 1, 0);

  always @(posedge memOeN) tOeRise = $time;

  always @(posedge memDqOe)
    check(($time - tOeRise) >= 5, "R7", "drive too soon after read strobe off",
          $time - tOeRise, 5);

  always @(negedge memWeN or negedge memCeN)
    if (!memWeN && !memCeN && !wrActive) begin
      wrActive = 1;
      tWrStart = $time;
    end

  always @(posedge memWeN or posedge memCeN)
    if (wrActive) begin
      wrActive = 0;
      check(($time - tWrStart) >= 7, "R9", "write pulse width", $time - tWrStart, 7);
      check(($time - tWrStart) == WE_C * 10, "R4", "write strobe cycles",
            $time - tWrStart, WE_C * 10);
      check(($time - tDataChg) >= 6, "R9", "data setup", $time - tDataChg, 6);
      check(($time - tAddrChg) >= 7, "R9", "address setup", $time - tAddrChg, 7);
      check(memDqOe, "R4", "data not driven at write end", memDqOe, 1);
      memArr[int'(memAddr)] = memDqOut;
    end

  // ---------------- requester tasks ----------------
  task automatic present(input bit wr, input logic [17:0] a, input logic [3:0] d);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [3:0] d);
    present(1'b1, a, d);
    for (int c = 1; c <= WE_C; c++) begin
      check({memCeN, memWeN, memOeN, memDqOe} == 4'b0011 && memDqOut == d &&
            memAddr == a, "R4", "write phase strobes",
            {memCeN, memWeN, memOeN, memDqOe}, 4'b0011);
      if (c == 1) check(!reqReady, "R3", "ready during write", reqReady, 0);
      @(negedge clk);
    end
    check({memCeN, memWeN, memDqOe} == 3'b111 && memAddr == a && memDqOut == d,
          "R4", "write end cycle", {memCeN, memWeN, memDqOe}, 3'b111);
    @(negedge clk);
  endtask

  task automatic doRead(input logic [17:0] a, input logic [3:0] exp);
    present(1'b0, a, 4'h0);
    for (int c = 1; c <= RD_C; c++) begin
      check({memCeN, memWeN, memOeN, memDqOe} == 4'b0100 && !rspValid, "R6",
            "read phase strobes", {memCeN, memWeN, memOeN, memDqOe, rspValid}, 5'b01000);
      if (c == 1) check(!reqReady, "R3", "ready during read", reqReady, 0);
      @(negedge clk);
    end
    check(rspValid, "R6", "response cycle", rspValid, 1);
    check({memCeN, memWeN, memOeN} == 3'b111, "R7", "turnaround strobes",
          {memCeN, memWeN, memOeN}, 3'b111);
    check(rspRdata == exp, "R8", "read data", rspRdata, exp);
    @(negedge clk);
    check(!rspValid && reqReady, "R6", "single response pulse",
          {rspValid, reqReady}, 2'b01);
  endtask

  // {write, addr[17:0], data[3:0]}; for reads the data field is the expectation
  localparam logic [22:0] VEC [16] = '{
    {1'b1, 18'h00000, 4'h5}, {1'b1, 18'h3FFFF, 4'hA},
    {1'b0, 18'h00000, 4'h5}, {1'b0, 18'h3FFFF, 4'hA},
    {1'b1, 18'h15555, 4'hF}, {1'b1, 18'h2AAAA, 4'h0},
    {1'b0, 18'h2AAAA, 4'h0}, {1'b0, 18'h15555, 4'hF},
    {1'b1, 18'h00001, 4'h3}, {1'b0, 18'h00001, 4'h3},
    {1'b1, 18'h00001, 4'hC}, {1'b0, 18'h00001, 4'hC},
    {1'b1, 18'h20000, 4'h9}, {1'b0, 18'h20000, 4'h9},
    {1'b0, 18'h3FFFF, 4'hA}, {1'b0, 18'h00000, 4'h5}
  };

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [3:0] shadow [16];
    bit         known  [16];
    for (int i = 0; i < 16; i++) begin shadow[i] = 4'h0; known[i] = 0; end

    // R2: reset state
    repeat (3) @(negedge clk);
    check({memCeN, memWeN, memOeN, memDqOe, reqReady, rspValid} == 6'b111000,
          "R2", "reset outputs", {memCeN, memWeN, memOeN, memDqOe, reqReady, rspValid},
          6'b111000);

    // R1: hold-off, with a write request pending the whole time
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00007; reqWdata = 4'h6;
    rstN = 1'b1;
    for (int k = 1; k <= WAKE; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < WAKE) begin
        check(!reqReady && memCeN, "R1", "quiet during hold-off",
              {reqReady, memCeN}, 2'b01);
        if (k == WAKE - 1) reqValid = 1'b0;
      end else begin
        check(reqReady && memCeN, "R1", "ready after hold-off",
              {reqReady, memCeN}, 2'b11);
      end
    end
    check(!memArr.exists(7), "R1", "hold-off request not written",
          memArr.exists(7), 0);

    // vector table
    foreach (VEC[i]) begin
      if (VEC[i][22]) doWrite(VEC[i][21:4], VEC[i][3:0]);
      else            doRead(VEC[i][21:4], VEC[i][3:0]);
    end

    // random mix over a small address set (R8)
    for (int n = 0; n < 48; n++) begin
      int unsigned r = $urandom;
      int idx = int'(r[3:0]);
      if (!known[idx] || r[4]) begin
        shadow[idx] = r[11:8];
        known[idx]  = 1;
        doWrite({14'h2B00, idx[3:0]}, r[11:8]);
      end else begin
        doRead({14'h2B00, idx[3:0]}, shadow[idx]);
      end
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule